// File: doc/BRIEF.md
# SMBus Target Byte Acknowledge Controller

This block is the byte-level receive side of a two-wire management bus target. It oversamples the clock and data lines with the system clock and finds bus conditions: START, repeated START and STOP. It collects the first byte after a START as a 7-bit address plus a direction bit. It compares the address with a programmed own address and acknowledges a match unconditionally. The controller uses this acknowledge to learn that the device is present.

In the write direction, every following byte goes to the host logic on a parallel strobe. Each strobe carries a position index: 0 for the command byte, then 1, 2 and so on. The host logic answers with a per-byte acceptance flag. If it refuses a byte, the block leaves the data line released in that byte's acknowledge slot, so the controller sees NACK. This works for every byte, including the last one before STOP. After a refusal the rest of the transfer is ignored. Read-direction data return, clock stretching and packet error codes are handled elsewhere.

The controller has seven states:
- `ST_IDLE` waits for a START.
- `ST_ADDR` shifts in the address byte.
- `ST_ADDR_ACK` drives the address acknowledge.
- `ST_DATA` shifts in a command or data byte.
- `ST_DATA_ACK` drives a data acknowledge.
- `ST_DATA_NACK` holds the line released through a refused slot.
- `ST_IGNORE` waits out the remainder of a transfer.

The transitions are as follows:
- START or repeated START moves any state to `ST_ADDR`.
- STOP moves any state to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a match, or to `ST_IDLE` on a mismatch. The decision is taken at the SCL fall after the 8th bit.
- `ST_ADDR_ACK` goes to `ST_DATA` for a write, or to `ST_IGNORE` for a read. This happens at the SCL fall after the 9th bit.
- `ST_DATA` goes to `ST_DATA_ACK` or `ST_DATA_NACK`, according to the acceptance flag.
- `ST_DATA_ACK` returns to `ST_DATA`.
- `ST_DATA_NACK` goes to `ST_IGNORE`.

Top module: `smb_ack_target`

## Requirements
- R1: A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. Each produces a one-cycle pulse on `start_o` or `stop_o`. START (including a repeated START) always restarts address reception. STOP always returns the block to idle, so bytes clocked after a STOP without a new START get no acknowledge.
- R2: The first byte after a START is taken MSB first as seven address bits followed by a direction bit (1 = read, 0 = write). When the address equals `own_addr_i`, the block pulls SDA low for the 9th clock and pulses `addr_hit_o`, whatever the value of `byte_ok_i`. `rw_o` then holds the direction bit.
- R3: `sda_low_o` changes only while SCL is low. It rises after the SCL fall that ends the 8th bit of a byte and falls after the SCL fall that ends the 9th bit.
- R4: A non-matching address is not acknowledged. No byte is reported and no acknowledge is given until the next START.
- R5: Each byte after an acknowledged write address produces a one-cycle `rx_valid_o` pulse after its 8th SCL rise. `rx_data_o` holds the byte (first bit in the MSB). `rx_index_o` is 0 for the first byte after the address and increases by one per acknowledged byte, saturating at its all-ones value.
- R6: `byte_ok_i` is sampled at the SCL fall after the 8th bit of every command or data byte. A value of 1 gives ACK and a value of 0 gives NACK in that byte's acknowledge slot, and this holds for the last byte before STOP too.
- R7: After a NACKed data byte, later bytes produce neither `rx_valid_o` nor an acknowledge until a STOP or repeated START.
- R8: After an acknowledged read address, the block releases SDA and reports no bytes until the next START or STOP.
- R9: After reset, `sda_low_o`, `rx_valid_o`, `addr_hit_o`, `start_o`, `stop_o` and `rx_index_o` are all zero.
- R10: A repeated START in the middle of a transfer, including one after a NACK, reopens address reception. The byte index then restarts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| own_addr_i | input | 7 | Programmed 7-bit target address |
| byte_ok_i | input | 1 | Host verdict for the current command/data byte |
| sda_low_o | output | 1 | Pull the data line low (open-drain enable) |
| rx_data_o | output | 8 | Last received command/data byte |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_index_o | output | IDX_W | Position of the byte since the address |
| addr_hit_o | output | 1 | One-cycle strobe on an own-address match |
| rw_o | output | 1 | Direction bit of the last matched address |
| start_o | output | 1 | One-cycle strobe on START/repeated START |
| stop_o | output | 1 | One-cycle strobe on STOP |

## Verification
The bench builds the block with `SYNC_STAGES = 2` and `IDX_W = 2`. The narrow index lets a five-byte write reach and hold the saturated index value of 3, which a wider default would need many more bytes to show. The bench runs the bus at 16 system clocks per bit. This leaves room for the two-stage synchronizer and the state register to place every acknowledge edge well inside the SCL low phase. Wired-AND modelling of the data line lets the bench read the acknowledges exactly as a controller would.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_DATA_NACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] scl_q;
    logic [LAST:0] sda_q;
    logic          scl_d;
    logic          sda_d;

    // Bus idles high, so every stage resets to one.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_q[g] <= 1'b1;
                    sda_q[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_q[g] <= scl_i;
                    sda_q[g] <= sda_i;
                end else begin
                    scl_q[g] <= scl_q[(g == 0) ? 0 : g - 1];
                    sda_q[g] <= sda_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_q[LAST];
            sda_d <= sda_q[LAST];
        end
    end

    assign scl_s     = scl_q[LAST];
    assign sda_s     = sda_q[LAST];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_bit_shift.sv
module smb_bit_shift
    import smb_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift,
    input  logic              bit_i,
    output logic [BYTE_W-1:0] data_o,
    output logic [CNT_W-1:0]  cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
            cnt_o  <= '0;
        end else if (clr) begin
            cnt_o  <= '0;
        end else if (shift) begin
            data_o <= {data_o[BYTE_W-2:0], bit_i};
            if (cnt_o != CNT_MAX) begin
                cnt_o <= cnt_o + 1'b1;
            end
        end
    end

endmodule

// File: rtl/smb_ack_target.sv
module smb_ack_target
    import smb_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IDX_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [6:0]        own_addr_i,
    input  logic              byte_ok_i,
    output logic              sda_low_o,
    output logic [7:0]        rx_data_o,
    output logic              rx_valid_o,
    output logic [IDX_W-1:0]  rx_index_o,
    output logic              addr_hit_o,
    output logic              rw_o,
    output logic              start_o,
    output logic              stop_o
);

    localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] IDX_MAX  = '1;

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [BYTE_W-1:0] shift_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic              clr_bits;
    logic              byte_end;
    logic              ack_end;
    logic              addr_match;
    logic              rw_q;
    logic [IDX_W-1:0]  idx_q;

    tgt_state_e state;
    tgt_state_e state_nxt;

    smb_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // Every 9-clock frame restarts its bit count at the fall ending the 9th bit.
    assign clr_bits   = start_det | (scl_fall & (bit_cnt == CNT_ACK));
    assign byte_end   = scl_fall & (bit_cnt == CNT_BYTE);
    assign ack_end    = scl_fall & (bit_cnt == CNT_ACK);
    assign addr_match = (shift_q[BYTE_W-1:1] == own_addr_i);

    smb_bit_shift u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_bits),
        .shift  (scl_rise),
        .bit_i  (sda_s),
        .data_o (shift_q),
        .cnt_o  (bit_cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state decision; bus conditions override every state.
    always_comb begin
        state_nxt = state;
        if (start_det) begin
            state_nxt = ST_ADDR;
        end else if (stop_det) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_nxt = ST_IDLE;
                end
                ST_ADDR: begin
                    if (byte_end) begin
                        state_nxt = addr_match ? ST_ADDR_ACK : ST_IDLE;
                    end
                end
                ST_ADDR_ACK: begin
                    if (ack_end) begin
                        state_nxt = rw_q ? ST_IGNORE : ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (byte_end) begin
                        state_nxt = byte_ok_i ? ST_DATA_ACK : ST_DATA_NACK;
                    end
                end
                ST_DATA_ACK: begin
                    if (ack_end) begin
                        state_nxt = ST_DATA;
                    end
                end
                ST_DATA_NACK: begin
                    if (ack_end) begin
                        state_nxt = ST_IGNORE;
                    end
                end
                ST_IGNORE: begin
                    state_nxt = ST_IGNORE;
                end
                default: begin
                    state_nxt = ST_IDLE;
                end
            endcase
        end
    end

    // Line drive follows the state alone.
    always_comb begin
        sda_low_o = (state == ST_ADDR_ACK) || (state == ST_DATA_ACK);
    end

    // Direction, byte position and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rw_q       <= 1'b0;
            idx_q      <= '0;
            rx_valid_o <= 1'b0;
            rx_data_o  <= '0;
            rx_index_o <= '0;
            addr_hit_o <= 1'b0;
            start_o    <= 1'b0;
            stop_o     <= 1'b0;
        end else begin
            start_o    <= start_det;
            stop_o     <= stop_det;
            addr_hit_o <= (state == ST_ADDR) && byte_end && addr_match && !start_det && !stop_det;
            rx_valid_o <= (state == ST_DATA) && scl_rise && (bit_cnt == CNT_LAST);
            if ((state == ST_DATA) && scl_rise && (bit_cnt == CNT_LAST)) begin
                rx_data_o  <= {shift_q[BYTE_W-2:0], sda_s};
                rx_index_o <= idx_q;
            end
            if ((state == ST_ADDR) && byte_end) begin
                rw_q <= shift_q[0];
            end
            if (state == ST_ADDR) begin
                idx_q <= '0;
            end else if ((state == ST_DATA_ACK) && ack_end && (idx_q != IDX_MAX)) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign rw_o = rw_q;

endmodule

// File: rtl/smb_ack_target_chk.sv
module smb_ack_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_low,
    input logic rx_valid,
    input logic addr_hit,
    input logic start_p,
    input logic stop_p
);

    // R3: the drive enable only moves while the sampled clock line is low
    a_r3_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low) |-> !scl_s);

    // R2: an address hit coincides with the acknowledge drive
    a_r2_hit_drives_ack: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |-> sda_low);

    // R5: a byte strobe arrives while the line is released (bit phase)
    a_r5_strobe_released: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !sda_low);

    // R1: a STOP strobe sees the line released
    a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |-> !sda_low);

    // R1: bus-condition and byte strobes never coincide
    a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_p, stop_p, rx_valid, addr_hit}));

endmodule

bind smb_ack_target smb_ack_target_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_low  (sda_low_o),
    .rx_valid (rx_valid_o),
    .addr_hit (addr_hit_o),
    .start_p  (start_o),
    .stop_p   (stop_o)
);

// File: tb/smb_ack_target_bench.sv
module smb_ack_target_bench;

    localparam int         IDX_W = 2;
    localparam logic [6:0] OWN   = 7'h2C;

    typedef struct packed {
        logic [6:0] a;
        logic       rw;
        logic [7:0] d0;
        logic       ok0;
        logic [7:0] d1;
        logic       ok1;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{7'h2C, 1'b0, 8'hA5, 1'b1, 8'h3C, 1'b1},
        '{7'h2C, 1'b0, 8'h81, 1'b1, 8'h7E, 1'b0},
        '{7'h2C, 1'b0, 8'h10, 1'b0, 8'h22, 1'b1},
        '{7'h2D, 1'b0, 8'h55, 1'b1, 8'h55, 1'b1},
        '{7'h2C, 1'b1, 8'h9A, 1'b1, 8'h9B, 1'b1},
        '{7'h6C, 1'b0, 8'hF0, 1'b1, 8'h0F, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic byte_ok = 1'b0;
    logic sda_bus;
    logic sda_low_o, rx_valid_o, addr_hit_o, rw_o, start_o, stop_o;
    logic [7:0] rx_data_o;
    logic [IDX_W-1:0] rx_index_o;

    int n_chk = 0, n_fail = 0;
    int rx_cnt = 0, hit_cnt = 0, start_cnt = 0, stop_cnt = 0, viol = 0;
    int last_data = 0, last_idx = 0;
    int idx_log [64];
    logic prev_low = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_low_o;

    smb_ack_target #(.SYNC_STAGES(2), .IDX_W(IDX_W)) u_smb_ack_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .own_addr_i (OWN),
        .byte_ok_i  (byte_ok),
        .sda_low_o  (sda_low_o),
        .rx_data_o  (rx_data_o),
        .rx_valid_o (rx_valid_o),
        .rx_index_o (rx_index_o),
        .addr_hit_o (addr_hit_o),
        .rw_o       (rw_o),
        .start_o    (start_o),
        .stop_o     (stop_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid_o) begin
                idx_log[rx_cnt % 64] = int'(rx_index_o);
                last_data = int'(rx_data_o);
                last_idx  = int'(rx_index_o);
                rx_cnt++;
            end
            if (addr_hit_o) hit_cnt++;
            if (start_o) start_cnt++;
            if (stop_o) stop_cnt++;
            if (sda_low_o != prev_low && scl_m) viol++;
            prev_low = sda_low_o;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        tick(3);
        sda_m = 1'b1;
        tick(5);
        scl_m = 1'b1;
        tick(8);
        sda_m = 1'b0;
        tick(8);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(3);
        sda_m = 1'b0;
        tick(5);
        scl_m = 1'b1;
        tick(8);
        sda_m = 1'b1;
        tick(8);
    endtask

    task automatic bus_bit(input logic b, output logic seen);
        tick(3);
        sda_m = b;
        tick(5);
        scl_m = 1'b1;
        tick(4);
        seen = sda_bus;
        tick(4);
        scl_m = 1'b0;
    endtask

    task automatic bus_byte(input logic [7:0] v, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(v[i], s);
        bus_bit(1'b1, s);
        acked = !s;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic ack;
        int rx0, st0, sp0, h0;
        tick(5);
        // R9: reset state
        check("R9 sda_low after reset", int'(sda_low_o), 0);
        check("R9 rx_valid after reset", int'(rx_valid_o), 0);
        check("R9 addr_hit after reset", int'(addr_hit_o), 0);
        check("R9 start/stop after reset", int'(start_o | stop_o), 0);
        check("R9 rx_index after reset", int'(rx_index_o), 0);
        rst_n = 1'b1;
        tick(5);

        // Table walk: R2 R4 R5 R6 R7 R8
        for (int v = 0; v < 6; v++) begin
            vec_t t;
            logic ea, e0, e1, a0, a1, a2;
            int exp_rx;
            t  = VEC[v];
            ea = (t.a == OWN);
            e0 = ea && !t.rw && t.ok0;
            e1 = e0 && t.ok1;
            exp_rx = ((ea && !t.rw) ? 1 : 0) + (e0 ? 1 : 0);
            rx0 = rx_cnt;
            byte_ok = 1'b0;
            bus_start();
            bus_byte({t.a, t.rw}, a0);
            byte_ok = t.ok0;
            bus_byte(t.d0, a1);
            byte_ok = t.ok1;
            bus_byte(t.d1, a2);
            bus_stop();
            tick(4);
            check($sformatf("R2/R4 vec%0d address ack", v), int'(a0), int'(ea));
            check($sformatf("R6 vec%0d first byte ack", v), int'(a1), int'(e0));
            check($sformatf("R6/R7 vec%0d second byte ack", v), int'(a2), int'(e1));
            check($sformatf("R5 vec%0d bytes reported", v), rx_cnt - rx0, exp_rx);
            if (exp_rx == 2) begin
                check($sformatf("R5 vec%0d last data", v), last_data, int'(t.d1));
                check($sformatf("R5 vec%0d last index", v), last_idx, 1);
            end else if (exp_rx == 1) begin
                check($sformatf("R5 vec%0d last data", v), last_data, int'(t.d0));
                check($sformatf("R5 vec%0d last index", v), last_idx, 0);
            end
            if (ea) check($sformatf("R8 vec%0d direction", v), int'(rw_o), int'(t.rw));
        end

        // R5: index saturation at 3 with IDX_W = 2
        rx0 = rx_cnt;
        byte_ok = 1'b0;
        bus_start();
        bus_byte({OWN, 1'b0}, ack);
        byte_ok = 1'b1;
        for (int i = 0; i < 5; i++) bus_byte(8'(8'h11 * (i + 1)), ack);
        bus_stop();
        tick(4);
        check("R5 saturation bytes", rx_cnt - rx0, 5);
        for (int i = 0; i < 5; i++)
            check($sformatf("R5 index of byte %0d", i), idx_log[(rx0 + i) % 64], (i < 3) ? i : 3);
        check("R5 last saturated data", last_data, 8'h55);

        // R7 then R10: NACK, ignored byte, repeated START
        st0 = start_cnt;
        byte_ok = 1'b0;
        bus_start();
        bus_byte({OWN, 1'b0}, ack);
        byte_ok = 1'b1;
        bus_byte(8'h40, ack);
        check("R6 command accepted", int'(ack), 1);
        byte_ok = 1'b0;
        bus_byte(8'h41, ack);
        check("R6 refused byte NACK", int'(ack), 0);
        rx0 = rx_cnt;
        byte_ok = 1'b1;
        bus_byte(8'h42, ack);
        check("R7 byte after NACK not acked", int'(ack), 0);
        check("R7 byte after NACK not reported", rx_cnt - rx0, 0);
        byte_ok = 1'b0;
        bus_start();
        bus_byte({OWN, 1'b0}, ack);
        check("R10 address after repeated START", int'(ack), 1);
        byte_ok = 1'b1;
        bus_byte(8'h43, ack);
        check("R10 byte acked after restart", int'(ack), 1);
        bus_stop();
        tick(4);
        check("R10 data after restart", last_data, 8'h43);
        check("R10 index restarts", last_idx, 0);
        check("R1 start strobes", start_cnt - st0, 2);

        // R1: STOP in the middle of an address, then bytes without START
        sp0 = stop_cnt;
        h0  = hit_cnt;
        rx0 = rx_cnt;
        bus_start();
        for (int i = 6; i >= 3; i--) bus_bit(OWN[i], ack);
        bus_stop();
        tick(4);
        check("R1 stop strobe", stop_cnt - sp0, 1);
        byte_ok = 1'b1;
        scl_m = 1'b0;
        bus_byte({OWN, 1'b0}, ack);
        check("R1 no ack after STOP without START", int'(ack), 0);
        bus_byte(8'h77, ack);
        check("R1 data ignored while idle", rx_cnt - rx0, 0);
        check("R1 no address hit while idle", hit_cnt - h0, 0);
        bus_stop();
        tick(4);

        // R3: drive moved only while SCL low
        check("R3 drive changes while SCL high", viol, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule